// File: doc/BRIEF.md
# Interleaved Four-Bank Block Fetcher

This block serves cache-block reads from a main store made of word-wide banks that work independently of one another. A request gives a word address and a size code. The block spends a fixed address phase, then starts every bank the block touches in the same cycle. Once the slowest access is done, it moves the words out over a single one-word return path, one per transfer slot. Consecutive words fall in consecutive banks, so a block of up to four words never needs the same bank twice. The access latency is therefore paid once per block, and only the transfer slots add up.

A mode input selects serial fetching instead. In that mode each word pays the whole cost in turn: address phase, bank access and transfer. This gives a reference timing for the same store. Each bank keeps track of its own cycle time, meaning access plus recovery. A request that needs a bank still inside that window waits at the end of its address phase until the bank is free again. The banks are behavioural: every word holds a value that is computed from its address.

Top module: `ilv_block_fetch`

## Requirements
- R1: While reset is held and right after it is released, `req_ready` is 1 and `rsp_valid` and `done` are 0.
- R2: The word at address a holds (a × 0x9E3779B1) XOR 0x5A5AC3C3, taken modulo 2^32 with a zero-extended. Words come back in ascending address order, and the address wraps modulo 2^ADDR_W. The bank is a mod 4 and the row is a div 4.
- R3: Size code 0 returns 1 word, code 1 returns 2 words, and codes 2 and 3 return 4 words. `rsp_last` is 1 on the final word only.
- R4: In interleaved mode (`req_serial`=0), count the cycle after the accepting edge as cycle 0. With no bank stall, word k has `rsp_valid` high for exactly cycle ADDR_CYC+ACC_CYC+(k+1)·XFER_CYC−1. This makes a 2-word block take 36 cycles and a 4-word block take 44 cycles.
- R5: In serial mode (`req_serial`=1) with no stall, word k is valid in cycle (k+1)·(ADDR_CYC+ACC_CYC+XFER_CYC)−1. A 1-word block takes 32 cycles and a 4-word block takes 128 cycles.
- R6: `done` is a one-cycle pulse in the cycle after the final word. `req_ready` is 1 from that cycle on and is 0 from acceptance until then.
- R7: A bank started at one edge cannot start again until ACC_CYC+RECOV_CYC edges later. A request that needs such a bank is delayed by exactly the remaining time. A request that needs only free banks is not delayed.
- R8: While a fetch is in progress, `req_valid`, `req_addr`, `req_size` and `req_serial` have no effect. The returned words and their timing match those of an undisturbed fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Fetcher idle, request accepted on this edge if valid |
| req_addr | input | ADDR_W | Word address of the first word |
| req_size | input | 2 | Size code: 0 = 1 word, 1 = 2 words, 2 or 3 = 4 words |
| req_serial | input | 1 | 1 = fetch words one after another, 0 = interleaved |
| rsp_valid | output | 1 | Returned word present this cycle |
| rsp_data | output | WORD_W | Returned word |
| rsp_last | output | 1 | Final word of the block |
| done | output | 1 | One-cycle pulse after the final word |

## Verification
Every result has a fixed due cycle. Counting from the cycle after the accepting edge, word k is due at ADDR+ACC+(k+1)·XFER−1 in interleaved mode, and at the end of its own address, access and transfer sequence in serial mode. Each start is pushed back to the edge where the needed bank's recovery runs out, and `done` is due one cycle after the last word. The bench keeps an arithmetic model of the per-bank start edges to compute these cycles. At every falling edge from acceptance to `done`, it compares the outputs with either the due word or with silence. An early, late, repeated or missing word therefore shows up in the exact cycle it goes wrong. Directed fetches against rested banks also check the totals of 32, 36, 44 and 128 cycles, and a stall of 7 cycles.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACC,
    ST_XFER
  } fetch_st_e;

  // size code -> number of words, clamped to the number of banks
  function automatic int unsigned words_of(input logic [1:0] code,
                                           input int unsigned bank_w);
    int unsigned e;
    e = (int'(code) > bank_w) ? bank_w : int'(code);
    return 1 << e;
  endfunction

endpackage

// File: rtl/ilv_bank.sv
module ilv_bank #(
  parameter int WORD_W   = 32,
  parameter int ROW_W    = 6,
  parameter int BANK_W   = 2,
  parameter int BANK_IDX = 0,
  parameter int ACC_CYC  = 24,
  parameter int BANK_CYC = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ROW_W-1:0]  row_i,
  output logic              free_o,
  output logic              data_ok_o,
  output logic [WORD_W-1:0] rdata_o
);

  localparam int ACC_W = $clog2(ACC_CYC + 1);
  localparam int CYC_W = $clog2(BANK_CYC + 1);
  localparam logic [BANK_W-1:0] IDX_V = BANK_W'(BANK_IDX);
  localparam logic [WORD_W-1:0] MIX  = WORD_W'(32'h9E37_79B1);
  localparam logic [WORD_W-1:0] SALT = WORD_W'(32'h5A5A_C3C3);

  logic [ACC_W-1:0]  acc_left_q, acc_left_d;
  logic [CYC_W-1:0]  cyc_left_q, cyc_left_d;
  logic [WORD_W-1:0] rdata_q, content;

  // behavioural store: each word's value is a function of its address
  always_comb begin
    content = (WORD_W'({row_i, IDX_V}) * MIX) ^ SALT;
  end

  always_comb begin
    acc_left_d = acc_left_q;
    cyc_left_d = cyc_left_q;
    if (start_i) begin
      acc_left_d = ACC_W'(ACC_CYC - 1);
      cyc_left_d = CYC_W'(BANK_CYC - 1);
    end else begin
      if (acc_left_q != '0) acc_left_d = acc_left_q - ACC_W'(1);
      if (cyc_left_q != '0) cyc_left_d = cyc_left_q - CYC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_left_q <= '0;
      cyc_left_q <= '0;
      rdata_q    <= '0;
    end else begin
      acc_left_q <= acc_left_d;
      cyc_left_q <= cyc_left_d;
      if (start_i) rdata_q <= content;
    end
  end

  assign free_o    = (cyc_left_q == '0);
  assign data_ok_o = (acc_left_q == '0);
  assign rdata_o   = rdata_q;

  // R7: the sequencer never starts a bank inside its cycle time
  p_start_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> free_o)
    else $error("bank %0d started while recovering", BANK_IDX);

  // R2: the read word is held until the bank is started again
  p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> $stable(rdata_o))
    else $error("bank %0d read word changed without a start", BANK_IDX);

  // R7: a started bank is busy in the next cycle
  p_busy_after_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !data_ok_o || (ACC_CYC == 1))
    else $error("bank %0d reported data too early", BANK_IDX);

endmodule

// File: rtl/ilv_launch_plan.sv
module ilv_launch_plan #(
  parameter int ADDR_W = 8,
  parameter int NBANK  = 4,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 6
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [BANK_W:0]   nwords_i,
  input  logic [BANK_W-1:0] widx_i,
  input  logic              serial_i,
  output logic [NBANK-1:0]  mask_o,
  output logic [ROW_W-1:0]  row_o [NBANK],
  output logic [BANK_W-1:0] cur_bank_o
);

  logic [ADDR_W-1:0] cur_addr;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [BANK_W-1:0] off;
    logic [ADDR_W-1:0] waddr;
    // position of this bank's word inside the block
    assign off       = BANK_W'(b) - base_i[BANK_W-1:0];
    assign waddr     = base_i + ADDR_W'(off);
    assign row_o[b]  = waddr[ADDR_W-1:BANK_W];
    assign mask_o[b] = serial_i ? (off == widx_i) : ({1'b0, off} < nwords_i);
  end

  assign cur_addr   = base_i + ADDR_W'(widx_i);
  assign cur_bank_o = cur_addr[BANK_W-1:0];

endmodule

// File: rtl/ilv_seq.sv
module ilv_seq
  import ilv_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NBANK    = 4,
  parameter int BANK_W   = 2,
  parameter int ADDR_CYC = 4,
  parameter int XFER_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_size_i,
  input  logic              req_serial_i,
  output logic              req_ready_o,
  output logic [ADDR_W-1:0] base_o,
  output logic [BANK_W:0]   nwords_o,
  output logic [BANK_W-1:0] widx_o,
  output logic              serial_o,
  input  logic [NBANK-1:0]  mask_i,
  input  logic [NBANK-1:0]  free_i,
  input  logic [NBANK-1:0]  data_ok_i,
  output logic              launch_o,
  output logic              rsp_valid_o,
  output logic              rsp_last_o,
  output logic              done_o
);

  localparam int CNT_MAX = (ADDR_CYC > XFER_CYC) ? ADDR_CYC : XFER_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  fetch_st_e          state_q, state_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [ADDR_W-1:0]  base_q;
  logic [BANK_W:0]    nwords_q;
  logic [BANK_W-1:0]  widx_q, widx_d;
  logic               serial_q;
  logic               done_q, done_d;
  logic               accept, all_free, all_ok, slot_end, is_last, launch;

  assign accept   = (state_q == ST_IDLE) && req_valid_i;
  assign all_free = &(free_i | ~mask_i);
  assign all_ok   = &(data_ok_i | ~mask_i);
  assign slot_end = (state_q == ST_XFER) && (cnt_q == '0);
  assign is_last  = (({1'b0, widx_q} + (BANK_W+1)'(1)) == nwords_q);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    widx_d  = widx_q;
    done_d  = 1'b0;
    launch  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          widx_d  = '0;
          cnt_d   = CNT_W'(ADDR_CYC - 1);
          state_d = ST_ADDR;
        end
      end
      ST_ADDR: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - CNT_W'(1);
        end else if (all_free) begin
          launch  = 1'b1;
          state_d = ST_ACC;
        end
      end
      ST_ACC: begin
        if (all_ok) begin
          cnt_d   = CNT_W'(XFER_CYC - 1);
          state_d = ST_XFER;
        end
      end
      ST_XFER: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - CNT_W'(1);
        end else if (is_last) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          widx_d = widx_q + BANK_W'(1);
          if (serial_q) begin
            cnt_d   = CNT_W'(ADDR_CYC - 1);
            state_d = ST_ADDR;
          end else begin
            cnt_d = CNT_W'(XFER_CYC - 1);
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      widx_q   <= '0;
      done_q   <= 1'b0;
      base_q   <= '0;
      nwords_q <= '0;
      serial_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      widx_q  <= widx_d;
      done_q  <= done_d;
      if (accept) begin
        base_q   <= req_addr_i;
        nwords_q <= (BANK_W+1)'(words_of(req_size_i, BANK_W));
        serial_q <= req_serial_i;
      end
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign base_o      = base_q;
  assign nwords_o    = nwords_q;
  assign widx_o      = widx_q;
  assign serial_o    = serial_q;
  assign launch_o    = launch;
  assign rsp_valid_o = slot_end;
  assign rsp_last_o  = slot_end && is_last;
  assign done_o      = done_q;

  // R6: the last word is followed by the done pulse
  p_last_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o && rsp_last_o |=> done_o)
    else $error("done did not follow the last word");

  // R6: done lasts one cycle
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o)
    else $error("done held for more than a cycle");

  // R6: no word is returned while idle
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready_o |-> !rsp_valid_o)
    else $error("word returned while idle");

  // R8: the captured request does not move during a fetch
  p_req_latched_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready_o |=> $stable(base_q) && $stable(nwords_q) && $stable(serial_q))
    else $error("request fields changed during a fetch");

endmodule

// File: rtl/ilv_block_fetch.sv
module ilv_block_fetch #(
  parameter int WORD_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int NBANK     = 4,
  parameter int ADDR_CYC  = 4,
  parameter int ACC_CYC   = 24,
  parameter int XFER_CYC  = 4,
  parameter int RECOV_CYC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_serial,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_data,
  output logic              rsp_last,
  output logic              done
);

  localparam int BANK_W   = $clog2(NBANK);
  localparam int ROW_W    = ADDR_W - BANK_W;
  localparam int BANK_CYC = ACC_CYC + RECOV_CYC;

  logic              rst_meta_q, rst_sync_q;
  logic [ADDR_W-1:0] base;
  logic [BANK_W:0]   nwords;
  logic [BANK_W-1:0] widx, cur_bank;
  logic              serial, launch;
  logic [NBANK-1:0]  mask, free, data_ok;
  logic [ROW_W-1:0]  row [NBANK];
  logic [WORD_W-1:0] bank_rdata [NBANK];

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  ilv_seq #(
    .ADDR_W(ADDR_W), .NBANK(NBANK), .BANK_W(BANK_W),
    .ADDR_CYC(ADDR_CYC), .XFER_CYC(XFER_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_sync_q),
    .req_valid_i(req_valid), .req_addr_i(req_addr),
    .req_size_i(req_size), .req_serial_i(req_serial),
    .req_ready_o(req_ready),
    .base_o(base), .nwords_o(nwords), .widx_o(widx), .serial_o(serial),
    .mask_i(mask), .free_i(free), .data_ok_i(data_ok),
    .launch_o(launch),
    .rsp_valid_o(rsp_valid), .rsp_last_o(rsp_last), .done_o(done)
  );

  ilv_launch_plan #(
    .ADDR_W(ADDR_W), .NBANK(NBANK), .BANK_W(BANK_W), .ROW_W(ROW_W)
  ) u_plan (
    .base_i(base), .nwords_i(nwords), .widx_i(widx), .serial_i(serial),
    .mask_o(mask), .row_o(row), .cur_bank_o(cur_bank)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_banks
    ilv_bank #(
      .WORD_W(WORD_W), .ROW_W(ROW_W), .BANK_W(BANK_W), .BANK_IDX(b),
      .ACC_CYC(ACC_CYC), .BANK_CYC(BANK_CYC)
    ) u_bank (
      .clk(clk), .rst_n(rst_sync_q),
      .start_i(launch && mask[b]),
      .row_i(row[b]),
      .free_o(free[b]),
      .data_ok_o(data_ok[b]),
      .rdata_o(bank_rdata[b])
    );
  end

  assign rsp_data = bank_rdata[cur_bank];

  // R3: a started block always touches at least one bank
  p_launch_nonempty_r3: assert property (@(posedge clk) disable iff (!rst_sync_q)
    launch |-> (mask != '0))
    else $error("start with no bank selected");

  // R5: a serial fetch starts exactly one bank at a time
  p_serial_one_bank_r5: assert property (@(posedge clk) disable iff (!rst_sync_q)
    launch && serial |-> $onehot0(mask) && (mask != '0))
    else $error("serial fetch started several banks");

endmodule

// File: tb/tb_ilv_block_fetch.sv
module tb_ilv_block_fetch;

  localparam int ADDR_CYC = 4;
  localparam int ACC_CYC  = 24;
  localparam int XFER_CYC = 4;
  localparam int RECOV    = 16;
  localparam int BANK_CYC = ACC_CYC + RECOV;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_serial;
  logic [7:0]  req_addr;
  logic [1:0]  req_size;
  logic        rsp_valid, rsp_last, done;
  logic [31:0] rsp_data;

  int cyc = 0;
  int vectors = 0;
  int miscompares = 0;
  int bank_last [4];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ilv_block_fetch dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_serial(req_serial),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_last(rsp_last), .done(done)
  );

  function automatic logic [31:0] mem_word(input int a);
    return (32'(a & 255) * 32'h9E37_79B1) ^ 32'h5A5A_C3C3;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s at cycle %0d: actual %h expected %h", req, what, cyc, act, exp);
    end
  endtask

  // one fetch, checked every cycle from acceptance to done
  task automatic fetch(input int a, input int sz, input bit ser, input bit poke,
                       input int gap, output int lat);
    int n, e_cyc, last_c, k, start;
    int vcyc [4];
    bit stalled;
    string tg, dtg;
    repeat (gap) @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = 8'(a); req_size = 2'(sz); req_serial = ser;
    @(negedge clk);
    e_cyc = cyc;
    req_valid = 1'b0;
    n = (sz >= 2) ? 4 : (1 << sz);
    stalled = 1'b0;
    if (!ser) begin
      int lt;
      lt = e_cyc + ADDR_CYC;
      for (int j = 0; j < n; j++)
        if (bank_last[(a + j) % 4] + BANK_CYC > lt) begin
          lt = bank_last[(a + j) % 4] + BANK_CYC;
          stalled = 1'b1;
        end
      for (int j = 0; j < n; j++) begin
        bank_last[(a + j) % 4] = lt;
        vcyc[j] = lt + ACC_CYC + (j + 1) * XFER_CYC - 1;
      end
    end else begin
      start = e_cyc;
      for (int j = 0; j < n; j++) begin
        int lt;
        lt = start + ADDR_CYC;
        if (bank_last[(a + j) % 4] + BANK_CYC > lt) begin
          lt = bank_last[(a + j) % 4] + BANK_CYC;
          stalled = 1'b1;
        end
        bank_last[(a + j) % 4] = lt;
        vcyc[j] = lt + ACC_CYC + XFER_CYC - 1;
        start = vcyc[j] + 1;
      end
    end
    last_c = vcyc[n-1];
    lat = last_c - e_cyc + 1;
    tg  = stalled ? "R7" : (ser ? "R5" : "R4");
    dtg = poke ? "R8" : "R2";
    k = 0;
    for (int c = e_cyc; c <= last_c + 1; c++) begin
      if (poke && c < last_c) begin
        req_valid = 1'b1; req_addr = 8'(c * 7); req_size = 2'(c); req_serial = c[0];
      end else begin
        req_valid = 1'b0;
      end
      if (c == last_c + 1) begin
        check(done == 1'b1, "R6", "done pulse", 32'(done), 32'd1);
        check(req_ready == 1'b1, "R6", "ready after done", 32'(req_ready), 32'd1);
        check(rsp_valid == 1'b0, "R6", "quiet at done", 32'(rsp_valid), 32'd0);
      end else if (k < n && c == vcyc[k]) begin
        check(rsp_valid == 1'b1, tg, "word due", 32'(rsp_valid), 32'd1);
        check(rsp_data == mem_word(a + k), dtg, "word value", rsp_data, mem_word(a + k));
        check(rsp_last == (k == n - 1), "R3", "last flag", 32'(rsp_last), 32'(k == n - 1));
        k++;
      end else begin
        check(rsp_valid == 1'b0, tg, "no word expected", 32'(rsp_valid), 32'd0);
        check(req_ready == 1'b0 && done == 1'b0, "R6", "busy flags",
              {30'd0, req_ready, done}, 32'd0);
      end
      if (c != last_c + 1) @(negedge clk);
    end
  endtask

  // watchdog
  always @(posedge clk) begin
    if (cyc == 150000) begin
      miscompares++;
      $display("FAIL watchdog all requirements: actual cycle %0d expected completion earlier", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int lat;
    for (int b = 0; b < 4; b++) bank_last[b] = -1000;
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_size = '0; req_serial = 1'b0;
    repeat (3) @(negedge clk);
    // R1: state during reset
    check(req_ready == 1'b1 && rsp_valid == 1'b0 && done == 1'b0, "R1", "in reset",
          {29'd0, req_ready, rsp_valid, done}, 32'b100);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(req_ready == 1'b1 && rsp_valid == 1'b0 && done == 1'b0, "R1", "after reset",
          {29'd0, req_ready, rsp_valid, done}, 32'b100);

    // R4: interleaved totals against rested banks
    fetch(0, 0, 1'b0, 1'b0, 60, lat);
    check(lat == 32, "R4", "1-word interleaved total", 32'(lat), 32'd32);
    fetch(0, 1, 1'b0, 1'b0, 60, lat);
    check(lat == 36, "R4", "2-word interleaved total", 32'(lat), 32'd36);
    fetch(8, 2, 1'b0, 1'b0, 60, lat);
    check(lat == 44, "R4", "4-word interleaved total", 32'(lat), 32'd44);
    // R3: size code 3 behaves as 4 words
    fetch(41, 3, 1'b0, 1'b0, 60, lat);
    check(lat == 44, "R3", "size code 3 total", 32'(lat), 32'd44);
    // R5: serial totals
    fetch(12, 2, 1'b1, 1'b0, 60, lat);
    check(lat == 128, "R5", "4-word serial total", 32'(lat), 32'd128);
    fetch(3, 0, 1'b1, 1'b0, 60, lat);
    check(lat == 32, "R5", "1-word serial total", 32'(lat), 32'd32);
    // R7: same bank back to back stalls 7 cycles, another bank does not
    fetch(16, 0, 1'b0, 1'b0, 60, lat);
    fetch(20, 0, 1'b0, 1'b0, 0, lat);
    check(lat == 39, "R7", "same-bank stall total", 32'(lat), 32'd39);
    fetch(21, 0, 1'b0, 1'b0, 0, lat);
    check(lat == 32, "R7", "free-bank total", 32'(lat), 32'd32);
    // R2: address wrap at the top of the space
    fetch(254, 2, 1'b0, 1'b0, 60, lat);
    // R8: inputs toggled during fetches are ignored
    fetch(100, 2, 1'b0, 1'b1, 60, lat);
    check(lat == 44, "R8", "disturbed interleaved total", 32'(lat), 32'd44);
    fetch(101, 1, 1'b1, 1'b1, 0, lat);

    // sweep: both modes, all size codes, low and high addresses, back to back
    for (int ser = 0; ser < 2; ser++)
      for (int sz = 0; sz < 4; sz++) begin
        for (int a = 0; a < 12; a++) fetch(a, sz, ser[0], 1'b0, 0, lat);
        for (int a = 250; a < 256; a++) fetch(a, sz, ser[0], 1'b0, 0, lat);
      end

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule